// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the sync and blanking pattern for a TFT panel. It keeps a pixel counter and a line counter, advances them on a pixel-clock enable, and from their positions decodes horizontal sync, vertical sync, the data-enable strobe and a start-of-frame pulse. The fetch engine uses that pulse to restart its read of the frame buffer. Every timing quantity comes from configuration inputs that hold register fields in their packed form: reduced by one, split across two registers, or given in units of 16 pixels. The block expands them itself.

On each axis the segments run in this order: active, front porch, sync, back porch. The line counter does not step at the end of a line. It steps on the pixel edge where horizontal sync ends, so vertical sync changes state on the trailing edge of horizontal sync. Each sync output has its own polarity inversion. Clearing the run input returns both counters to the origin and holds every output idle.

There is no data stream through the block, so no port has a valid/ready handshake. All pins are plain control or status levels. The configuration must stay stable while `raster_on` is high.

Top module: `raster_sync_gen`

## Requirements
- R1: The active width in pixels is (`width_m1` + 1) × 16. In every active line, `de` is high for exactly the x positions 0 to width-1.
- R2: The horizontal front porch is {`hfp_hi`,`hfp_lo`} + 1 and the back porch is {`hbp_hi`,`hbp_lo`} + 1, each assembled from an 8-bit low part and a 2-bit high part. x counts 0 up to the last position of the line and then wraps to 0. The segments run in the order active, front porch, sync, back porch.
- R3: The horizontal sync width is {`hsw_hi`,`hsw_lo`} + 1, assembled from 6 low bits and 4 high bits. Sync is active for x from width+front porch up to that value plus the sync width, minus one.
- R4: The vertical front porch `vfp` and back porch `vbp` are line counts used as given, and 0 means no such lines. The vertical sync width is `vsw_m1` + 1.
- R5: The number of active lines is {`lines_ext`,`lines_lo`} + 1, where `lines_ext` is bit 10. This allows up to 2048 lines.
- R6: y advances, and wraps after the last line, on the pixel step that leaves the last horizontal sync position. vsync therefore changes only in the cycle in which hsync returns to inactive.
- R7: `hs_inv`/`vs_inv` = 1 makes the matching sync active-low. The inactive level of each sync equals its inversion control.
- R8: `de` is high only when x is within the active width and y is within the active lines, and only while `raster_on` is high.
- R9: `frame_start` is high for a cycle in which `raster_on` and `pix_en` are high and the position is x=0, y=0. It is low in every other cycle.
- R10: While `raster_on` is low, x and y read 0, `de` and `frame_start` are low, and both syncs sit at their inactive levels. After reset the block is in this state. When `raster_on` returns, the scan starts from x=0, y=0.
- R11: A cycle with `pix_en` low leaves x and y unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel step per high cycle |
| raster_on | input | 1 | Run control; low clears and idles the scan |
| width_m1 | input | 7 | Active width in units of 16 pixels, minus one |
| hfp_lo | input | 8 | Horizontal front porch minus one, low part |
| hfp_hi | input | 2 | Horizontal front porch minus one, high part |
| hbp_lo | input | 8 | Horizontal back porch minus one, low part |
| hbp_hi | input | 2 | Horizontal back porch minus one, high part |
| hsw_lo | input | 6 | Horizontal sync width minus one, low part |
| hsw_hi | input | 4 | Horizontal sync width minus one, high part |
| vfp | input | 8 | Vertical front porch in lines |
| vbp | input | 8 | Vertical back porch in lines |
| vsw_m1 | input | 6 | Vertical sync width minus one |
| lines_lo | input | 10 | Active lines minus one, bits 9:0 |
| lines_ext | input | 1 | Active lines minus one, bit 10 |
| hs_inv | input | 1 | Invert hsync |
| vs_inv | input | 1 | Invert vsync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| x | output | 13 | Current pixel position in the line |
| y | output | 13 | Current line position in the frame |
| frame_start | output | 1 | Start-of-frame pulse for the fetch engine |

## Verification
Two events can fall in the same pixel step. The first is the line counter stepping, or wrapping to line 0, at the end of horizontal sync. The second is hsync deasserting, with vsync entering or leaving its window at that same edge. The sweeps run every frame of three small configurations through these coincidences: zero and non-zero vertical porches, high parts of the split fields set, and a line count that uses the extension bit. Each cycle is compared with positions computed arithmetically from the number of enabled pixel steps. A second coincidence is a run-clear that arrives while `pix_en` is high. It is provoked in the middle of a frame, and the bench expects the idle outputs in that cycle and a scan that restarts at the origin.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  // default field widths of the packed timing configuration
  localparam int unsigned DEF_WF_W  = 7;   // width in 16-pixel units
  localparam int unsigned DEF_HLO_W = 8;   // horizontal porch low part
  localparam int unsigned DEF_HHI_W = 2;   // horizontal porch high part
  localparam int unsigned DEF_SLO_W = 6;   // hsync width low part
  localparam int unsigned DEF_SHI_W = 4;   // hsync width high part
  localparam int unsigned DEF_VP_W  = 8;   // vertical porches
  localparam int unsigned DEF_VS_W  = 6;   // vsync width
  localparam int unsigned DEF_LLO_W = 10;  // active lines low part
  localparam int unsigned DEF_SHIFT = 4;   // log2 of the width unit

  localparam int unsigned H_MAX = (2 ** DEF_WF_W) * (2 ** DEF_SHIFT)
                                + 2 * (2 ** (DEF_HLO_W + DEF_HHI_W))
                                + 2 ** (DEF_SLO_W + DEF_SHI_W);
  localparam int unsigned V_MAX = 2 ** (DEF_LLO_W + 1)
                                + 2 * (2 ** DEF_VP_W) + 2 ** DEF_VS_W;
  localparam int unsigned CNT_W = $clog2(((H_MAX > V_MAX) ? H_MAX : V_MAX) + 1);

  // segment boundaries of one scan axis, all as counter positions
  typedef struct packed {
    logic [CNT_W-1:0] act_end;   // first position past the active run
    logic [CNT_W-1:0] sync_beg;  // first sync position
    logic [CNT_W-1:0] sync_end;  // first position past sync
    logic [CNT_W-1:0] total;     // positions per axis period
  } rsg_lim_t;
endpackage

// File: rtl/rsg_cfg_decode.sv
module rsg_cfg_decode
  import rsg_pkg::*;
#(
  parameter int unsigned WF_W  = DEF_WF_W,
  parameter int unsigned HLO_W = DEF_HLO_W,
  parameter int unsigned HHI_W = DEF_HHI_W,
  parameter int unsigned SLO_W = DEF_SLO_W,
  parameter int unsigned SHI_W = DEF_SHI_W,
  parameter int unsigned VP_W  = DEF_VP_W,
  parameter int unsigned VS_W  = DEF_VS_W,
  parameter int unsigned LLO_W = DEF_LLO_W,
  parameter int unsigned SHIFT = DEF_SHIFT
) (
  input  logic [WF_W-1:0]  width_m1,
  input  logic [HLO_W-1:0] hfp_lo,
  input  logic [HHI_W-1:0] hfp_hi,
  input  logic [HLO_W-1:0] hbp_lo,
  input  logic [HHI_W-1:0] hbp_hi,
  input  logic [SLO_W-1:0] hsw_lo,
  input  logic [SHI_W-1:0] hsw_hi,
  input  logic [VP_W-1:0]  vfp,
  input  logic [VP_W-1:0]  vbp,
  input  logic [VS_W-1:0]  vsw_m1,
  input  logic [LLO_W-1:0] lines_lo,
  input  logic             lines_ext,
  output rsg_lim_t         h_lim,
  output rsg_lim_t         v_lim
);
  logic [CNT_W-1:0] h_act, h_fp, h_sw, h_bp;
  logic [CNT_W-1:0] v_act, v_fp, v_sw, v_bp;

  // expand the packed fields into plain counts
  always_comb begin
    h_act = (CNT_W'(width_m1) + 1'b1) << SHIFT;
    h_fp  = CNT_W'({hfp_hi, hfp_lo}) + 1'b1;
    h_bp  = CNT_W'({hbp_hi, hbp_lo}) + 1'b1;
    h_sw  = CNT_W'({hsw_hi, hsw_lo}) + 1'b1;
    v_act = CNT_W'({lines_ext, lines_lo}) + 1'b1;
    v_fp  = CNT_W'(vfp);
    v_bp  = CNT_W'(vbp);
    v_sw  = CNT_W'(vsw_m1) + 1'b1;
  end

  // accumulate segment boundaries: active, front porch, sync, back porch
  always_comb begin
    h_lim.act_end  = h_act;
    h_lim.sync_beg = h_act + h_fp;
    h_lim.sync_end = h_lim.sync_beg + h_sw;
    h_lim.total    = h_lim.sync_end + h_bp;
    v_lim.act_end  = v_act;
    v_lim.sync_beg = v_act + v_fp;
    v_lim.sync_end = v_lim.sync_beg + v_sw;
    v_lim.total    = v_lim.sync_end + v_bp;
  end
endmodule

// File: rtl/rsg_axis.sv
module rsg_axis
  import rsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  rsg_lim_t         lim,
  output logic [CNT_W-1:0] cnt,
  output logic             in_act,
  output logic             in_sync,
  output logic             sync_last,
  output logic             at_zero
);
  logic wrap;

  // >= so that a shrunk period still folds the counter back
  assign wrap = (cnt >= lim.total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assign in_act    = (cnt < lim.act_end);
  assign in_sync   = (cnt >= lim.sync_beg) && (cnt < lim.sync_end);
  assign sync_last = (cnt == lim.sync_end - 1'b1);
  assign at_zero   = (cnt == '0);
endmodule

// File: rtl/rsg_out.sv
module rsg_out
  import rsg_pkg::*;
(
  input  logic             run,
  input  logic             pix_en,
  input  logic             h_act,
  input  logic             v_act,
  input  logic             h_sync,
  input  logic             v_sync,
  input  logic             h_zero,
  input  logic             v_zero,
  input  logic             hs_inv,
  input  logic             vs_inv,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] x,
  output logic [CNT_W-1:0] y,
  output logic             frame_start
);
  // everything idles in the cycle the run control drops
  assign hsync       = (run & h_sync) ^ hs_inv;
  assign vsync       = (run & v_sync) ^ vs_inv;
  assign de          = run & h_act & v_act;
  assign x           = run ? hcnt : '0;
  assign y           = run ? vcnt : '0;
  assign frame_start = run & pix_en & h_zero & v_zero;
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int unsigned WF_W  = DEF_WF_W,
  parameter int unsigned HLO_W = DEF_HLO_W,
  parameter int unsigned HHI_W = DEF_HHI_W,
  parameter int unsigned SLO_W = DEF_SLO_W,
  parameter int unsigned SHI_W = DEF_SHI_W,
  parameter int unsigned VP_W  = DEF_VP_W,
  parameter int unsigned VS_W  = DEF_VS_W,
  parameter int unsigned LLO_W = DEF_LLO_W,
  parameter int unsigned SHIFT = DEF_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             raster_on,
  input  logic [WF_W-1:0]  width_m1,
  input  logic [HLO_W-1:0] hfp_lo,
  input  logic [HHI_W-1:0] hfp_hi,
  input  logic [HLO_W-1:0] hbp_lo,
  input  logic [HHI_W-1:0] hbp_hi,
  input  logic [SLO_W-1:0] hsw_lo,
  input  logic [SHI_W-1:0] hsw_hi,
  input  logic [VP_W-1:0]  vfp,
  input  logic [VP_W-1:0]  vbp,
  input  logic [VS_W-1:0]  vsw_m1,
  input  logic [LLO_W-1:0] lines_lo,
  input  logic             lines_ext,
  input  logic             hs_inv,
  input  logic             vs_inv,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] x,
  output logic [CNT_W-1:0] y,
  output logic             frame_start
);
  rsg_lim_t         h_lim, v_lim;
  logic [CNT_W-1:0] hcnt, vcnt;
  logic             h_act, h_sync, h_sync_last, h_zero;
  logic             v_act, v_sync, v_sync_last, v_zero;
  logic             h_step, v_step, clr;

  assign clr    = ~raster_on;
  assign h_step = raster_on & pix_en;
  // line advances on the step that ends horizontal sync
  assign v_step = h_step & h_sync_last;

  rsg_cfg_decode #(
    .WF_W(WF_W), .HLO_W(HLO_W), .HHI_W(HHI_W), .SLO_W(SLO_W),
    .SHI_W(SHI_W), .VP_W(VP_W), .VS_W(VS_W), .LLO_W(LLO_W), .SHIFT(SHIFT)
  ) u_dec (
    .width_m1 (width_m1),
    .hfp_lo   (hfp_lo),
    .hfp_hi   (hfp_hi),
    .hbp_lo   (hbp_lo),
    .hbp_hi   (hbp_hi),
    .hsw_lo   (hsw_lo),
    .hsw_hi   (hsw_hi),
    .vfp      (vfp),
    .vbp      (vbp),
    .vsw_m1   (vsw_m1),
    .lines_lo (lines_lo),
    .lines_ext(lines_ext),
    .h_lim    (h_lim),
    .v_lim    (v_lim)
  );

  rsg_axis u_hax (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .step     (h_step),
    .lim      (h_lim),
    .cnt      (hcnt),
    .in_act   (h_act),
    .in_sync  (h_sync),
    .sync_last(h_sync_last),
    .at_zero  (h_zero)
  );

  rsg_axis u_vax (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .step     (v_step),
    .lim      (v_lim),
    .cnt      (vcnt),
    .in_act   (v_act),
    .in_sync  (v_sync),
    .sync_last(v_sync_last),
    .at_zero  (v_zero)
  );

  rsg_out u_out (
    .run        (raster_on),
    .pix_en     (pix_en),
    .h_act      (h_act),
    .v_act      (v_act),
    .h_sync     (h_sync),
    .v_sync     (v_sync),
    .h_zero     (h_zero),
    .v_zero     (v_zero),
    .hs_inv     (hs_inv),
    .vs_inv     (vs_inv),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .x          (x),
    .y          (y),
    .frame_start(frame_start)
  );

  // last vertical sync line needs no consumer at this level
  logic unused_ok;
  assign unused_ok = v_sync_last;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker
  import rsg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             raster_on,
  input logic             hs_inv,
  input logic             vs_inv,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [CNT_W-1:0] x,
  input logic [CNT_W-1:0] y,
  input logic             frame_start
);
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !raster_on |-> (x == '0 && y == '0 && !de && !frame_start &&
                    hsync == hs_inv && vsync == vs_inv));

  assert_hold_without_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (raster_on && !pix_en) |=> (!raster_on || ($stable(x) && $stable(y))));

  assert_start_at_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (x == '0 && y == '0 && pix_en && de));

  assert_de_outside_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (raster_on && hsync == hs_inv && vsync == vs_inv));

  assert_vsync_on_hsync_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && raster_on && $past(raster_on) && $stable(hs_inv) && $stable(vs_inv) &&
     ((vsync ^ vs_inv) != $past(vsync ^ vs_inv)))
    |-> ($past(hsync ^ hs_inv) && !(hsync ^ hs_inv)));

  assert_x_steps_or_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && raster_on && $past(raster_on) && $past(pix_en))
    |-> (x == $past(x) + 1'b1 || x == '0));
endmodule

bind raster_sync_gen rsg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en     (pix_en),
  .raster_on  (raster_on),
  .hs_inv     (hs_inv),
  .vs_inv     (vs_inv),
  .hsync      (hsync),
  .vsync      (vsync),
  .de         (de),
  .x          (x),
  .y          (y),
  .frame_start(frame_start)
);

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
  import rsg_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             pix_en = 1'b0;
  logic             raster_on = 1'b0;
  logic [6:0]       width_m1 = '0;
  logic [7:0]       hfp_lo = '0, hbp_lo = '0;
  logic [1:0]       hfp_hi = '0, hbp_hi = '0;
  logic [5:0]       hsw_lo = '0;
  logic [3:0]       hsw_hi = '0;
  logic [7:0]       vfp = '0, vbp = '0;
  logic [5:0]       vsw_m1 = '0;
  logic [9:0]       lines_lo = '0;
  logic             lines_ext = 1'b0;
  logic             hs_inv = 1'b0, vs_inv = 1'b0;
  logic             hsync, vsync, de, frame_start;
  logic [CNT_W-1:0] x, y;

  raster_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .raster_on(raster_on),
    .width_m1(width_m1), .hfp_lo(hfp_lo), .hfp_hi(hfp_hi),
    .hbp_lo(hbp_lo), .hbp_hi(hbp_hi), .hsw_lo(hsw_lo), .hsw_hi(hsw_hi),
    .vfp(vfp), .vbp(vbp), .vsw_m1(vsw_m1), .lines_lo(lines_lo),
    .lines_ext(lines_ext), .hs_inv(hs_inv), .vs_inv(vs_inv),
    .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y),
    .frame_start(frame_start)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 0;
  longint k = 0;
  longint HW, HSB, HSE, HT, VA, VSB, VSE, VT;
  bit     rnd = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit     prev_on = 0, prev_pix = 0;
  longint px = 0, py = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic set_cfg(input int wm1, input int hfl, input int hfh, input int hbl,
                         input int hbh, input int hsl, input int hsh, input int vf,
                         input int vb, input int vsm1, input int llo, input int lext,
                         input bit hi, input bit vi);
    width_m1 = 7'(wm1); hfp_lo = 8'(hfl); hfp_hi = 2'(hfh);
    hbp_lo = 8'(hbl); hbp_hi = 2'(hbh); hsw_lo = 6'(hsl); hsw_hi = 4'(hsh);
    vfp = 8'(vf); vbp = 8'(vb); vsw_m1 = 6'(vsm1);
    lines_lo = 10'(llo); lines_ext = lext[0]; hs_inv = hi; vs_inv = vi;
    HW  = (wm1 + 1) * 16;
    HSB = HW + hfh * 256 + hfl + 1;
    HSE = HSB + hsh * 64 + hsl + 1;
    HT  = HSE + hbh * 256 + hbl + 1;
    VA  = lext * 1024 + llo + 1;
    VSB = VA + vf;
    VSE = VSB + vsm1 + 1;
    VT  = VSE + vb;
  endtask

  task automatic step(input bit ron);
    longint eh, ev;
    bit ede, ehs, evs, efs;
    @(negedge clk);
    raster_on = ron;
    if (rnd) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_en = (lfsr[1:0] != 2'b00);
    end else begin
      pix_en = 1'b1;
    end
    #1;
    if (ron) begin
      eh  = k % HT;
      ev  = ((k + HT - HSE) / HT) % VT;  // lines start at each hsync trailing edge
      ede = (eh < HW) && (ev < VA);
      ehs = (eh >= HSB) && (eh < HSE);
      evs = (ev >= VSB) && (ev < VSE);
      efs = pix_en && eh == 0 && ev == 0;
    end else begin
      eh = 0; ev = 0; ede = 0; ehs = 0; evs = 0; efs = 0;
    end
    chk(x == CNT_W'(eh), "R2 x position", longint'(x), eh);
    chk(y == CNT_W'(ev), "R5 y position", longint'(y), ev);
    chk(de == ede, "R1 R8 data enable", longint'(de), longint'(ede));
    chk(hsync == (ehs ^ hs_inv), "R3 R7 hsync", longint'(hsync), longint'(ehs ^ hs_inv));
    chk(vsync == (evs ^ vs_inv), "R4 R6 R7 vsync", longint'(vsync), longint'(evs ^ vs_inv));
    chk(frame_start == efs, "R9 frame start", longint'(frame_start), longint'(efs));
    if (!ron)
      chk(x == '0 && y == '0 && !de && hsync == hs_inv && vsync == vs_inv,
          "R10 idle while off", longint'(x), 0);
    if (ron && prev_on && !prev_pix)
      chk(longint'(x) == px && longint'(y) == py, "R11 hold without enable", longint'(x), px);
    prev_on = ron; prev_pix = pix_en; px = longint'(x); py = longint'(y);
    if (!ron) k = 0;
    else if (pix_en) k++;
  endtask

  initial begin
    #(2500000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // small config A: W=16, fp 2, sync 3, bp 1; 3 lines, vfp 1, vsync 2, vbp 0
    set_cfg(0, 1, 0, 0, 0, 2, 0, 1, 0, 1, 2, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(x == '0 && y == '0 && !de && !frame_start && hsync == 1'b0 && vsync == 1'b0,
        "R10 reset state", longint'(x), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rnd = 0;
    repeat (300) step(1);
    repeat (4) step(0);     // clear mid-frame with pix_en high
    repeat (200) step(1);
    step(0);
    // config B: high parts set, vfp 0, both syncs inverted, sparse pix_en
    set_cfg(1, 3, 1, 0, 2, 1, 1, 0, 1, 0, 1, 0, 1, 1);
    rnd = 1;
    repeat (8000) step(1);
    step(0);
    // config C: line extension bit (1025 lines), vfp 2, vsync 6
    set_cfg(0, 0, 0, 0, 0, 0, 0, 2, 0, 5, 0, 1, 0, 1);
    rnd = 0;
    repeat (19700) step(1);
    step(0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule